// File: doc/BRIEF.md
# Stateful In-Memory Logic Sequencer

This block models one nonvolatile logic cell, which has a single stored bit and three drive terminals (a gate and two electrodes), together with the controller that drives it. The cell never computes a function combinationally. Its stored bit changes only while a pulse is applied. During a pulse, the gate and the two electrodes select one of three actions: set the bit, clear it, or leave it as it is. To get any two-input Boolean function of operands p and q, the controller first forces the bit to a chosen starting value (0, 1, p or q). It then drives all three terminals at once from literals of p and q. Finally it reads the bit back with a non-disturbing read step.

A client presents a 4-bit function code and the two operands while `ready_o` is high and raises `start_i` for one cycle. The controller then runs the initialize pulse, the write pulse and the read step. It returns the result on `result_o` with a one-cycle `done_o` strobe. The terminal levels and the pulse window are visible at the ports. The pulse length in clock cycles is the parameter `PULSE_CYC`, with a default of 3. The reset input is active low and asynchronous. It is expected to be already deasserted in step with `clk`.

Top module: `stateful_logic_seq`

## Requirements
- R1: The function code is the truth table of the result: `result_o` equals bit `{p,q}` of `func_i` (bit 0 is f(0,0), bit 1 is f(0,1), bit 2 is f(1,0), bit 3 is f(1,1)) for all 16 codes and all four operand pairs.
- R2: While `pulse_o` is high, each clock edge updates the stored bit: it becomes 1 when G=1, T1=1, T2=0; it becomes 0 when G=1, T1=0, T2=1; otherwise it keeps its value.
- R3: During the initialize pulse the terminals (G,T1,T2) are (1,1,0) to start from 1 and (1,0,1) to start from 0. Code 0x0 and code 0x8 start from 0. Code 0xF and code 0x7 start from 1. Code 0xC starts from p and code 0xA starts from q.
- R4: For code 0x7 (NAND) the write pulse drives G=p, T1=0, T2=q.
- R5: Each of the two pulses lasts exactly `PULSE_CYC` cycles, so `pulse_o` is high for 2·`PULSE_CYC` cycles per operation. `done_o` rises 2·`PULSE_CYC`+1 clock edges after the edge that accepts `start_i`.
- R6: The read step lasts one cycle, with `pulse_o` low and the terminals at (1,0,0).
- R7: `ready_o` is high only while idle and is low whenever `pulse_o` is high. A `start_i` raised while busy is ignored: it produces no extra `done_o`, and the running operation returns its own result.
- R8: `done_o` is high for exactly one cycle per accepted operation, and `result_o` does not change until the next `done_o`.
- R9: Reset returns the controller to idle, even in the middle of an operation: `ready_o` goes high and no `done_o` follows. Reset leaves `result_o` unchanged.
- R10: The stored bit never changes while `pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller |
| start_i | input | 1 | Request to start an operation, taken when ready_o is high |
| func_i | input | 4 | Function code, written as a truth table |
| p_i | input | 1 | First operand |
| q_i | input | 1 | Second operand |
| ready_o | output | 1 | Controller idle, able to accept start_i |
| done_o | output | 1 | One-cycle strobe when result_o is updated |
| result_o | output | 1 | Bit read from the cell at the end of the last operation |
| pulse_o | output | 1 | A set/reset pulse is being applied to the cell |
| drv_g_o | output | 1 | Gate terminal level |
| drv_t1_o | output | 1 | Top-electrode terminal level |
| drv_t2_o | output | 1 | Source terminal level |

## Verification
Some behaviour is checked on every cycle. The bound checker checks the cell's next-state rule under set and reset pulses, and that the stored bit holds whenever no pulse is applied. It also checks the single-cycle done strobe, that `result_o` holds between completions, that ready stays low during pulses, and the quiet terminal levels of the read step. Other behaviour only the bench's scenarios can show. These are the correctness of all 64 function/operand combinations against a reference truth table, the chosen starting values and the NAND terminal assignment, the exact pulse and completion latencies, the rejection of a start during an operation, and the recovery from a reset in the middle of an operation.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Starting value forced by the initialize pulse
  typedef enum logic [1:0] {INIT_ZERO, INIT_ONE, INIT_P, INIT_Q} init_sel_e;

  // Literal that drives one terminal during the write pulse
  typedef enum logic [2:0] {LIT_LO, LIT_HI, LIT_P, LIT_Q, LIT_NP, LIT_NQ} lit_e;

  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_WRITE, PH_READ} phase_e;

  typedef struct packed {
    init_sel_e init;
    lit_e      g;
    lit_e      t1;
    lit_e      t2;
  } recipe_t;

  // Recipe per truth-table code; every entry derived from the hold/set/clear rule
  function automatic recipe_t recipe_for(input logic [3:0] code);
    recipe_t r;
    unique case (code)
      4'h0: r = '{INIT_ZERO, LIT_LO, LIT_LO, LIT_LO};  // constant 0
      4'hF: r = '{INIT_ONE,  LIT_LO, LIT_LO, LIT_LO};  // constant 1
      4'hC: r = '{INIT_P,    LIT_LO, LIT_LO, LIT_LO};  // p
      4'hA: r = '{INIT_Q,    LIT_LO, LIT_LO, LIT_LO};  // q
      4'h3: r = '{INIT_ONE,  LIT_HI, LIT_LO, LIT_P };  // not p
      4'h5: r = '{INIT_ONE,  LIT_HI, LIT_LO, LIT_Q };  // not q
      4'h7: r = '{INIT_ONE,  LIT_P,  LIT_LO, LIT_Q };  // nand
      4'h8: r = '{INIT_ZERO, LIT_P,  LIT_Q,  LIT_LO};  // and
      4'hE: r = '{INIT_P,    LIT_HI, LIT_Q,  LIT_LO};  // or
      4'h1: r = '{INIT_ZERO, LIT_NP, LIT_NQ, LIT_LO};  // nor
      4'h6: r = '{INIT_P,    LIT_Q,  LIT_NP, LIT_P };  // xor
      4'h9: r = '{INIT_P,    LIT_NQ, LIT_NP, LIT_P };  // xnor
      4'hB: r = '{INIT_ONE,  LIT_P,  LIT_LO, LIT_NQ};  // p implies q
      4'hD: r = '{INIT_ONE,  LIT_Q,  LIT_LO, LIT_NP};  // q implies p
      4'h4: r = '{INIT_ZERO, LIT_P,  LIT_NQ, LIT_LO};  // p and not q
      default: r = '{INIT_ZERO, LIT_Q, LIT_NP, LIT_LO}; // 4'h2: q and not p
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsq_recipe_decode.sv
module lsq_recipe_decode
  import lsq_pkg::*;
(
  input  logic [3:0] func_i,
  input  logic       p_i,
  input  logic       q_i,
  output logic       init_val_o,
  output logic [2:0] write_drv_o   // {G, T1, T2}
);
  localparam int N_TERM = 3;

  recipe_t rcp;
  lit_e    lits [N_TERM];

  always_comb begin
    rcp     = recipe_for(func_i);
    lits[2] = rcp.g;
    lits[1] = rcp.t1;
    lits[0] = rcp.t2;
  end

  always_comb begin
    unique case (rcp.init)
      INIT_ZERO: init_val_o = 1'b0;
      INIT_ONE:  init_val_o = 1'b1;
      INIT_P:    init_val_o = p_i;
      default:   init_val_o = q_i;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < N_TERM; i++) begin : g_term
      logic lvl;
      always_comb begin
        unique case (lits[i])
          LIT_HI:  lvl = 1'b1;
          LIT_P:   lvl = p_i;
          LIT_Q:   lvl = q_i;
          LIT_NP:  lvl = ~p_i;
          LIT_NQ:  lvl = ~q_i;
          default: lvl = 1'b0;
        endcase
      end
      assign write_drv_o[i] = lvl;
    end
  endgenerate

endmodule

// File: rtl/lsq_phase_ctrl.sv
module lsq_phase_ctrl
  import lsq_pkg::*;
#(
  parameter int PULSE_CYC = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   accept_o
);
  localparam int              CNT_W    = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept_o = (phase_q == PH_IDLE) && start_i;
  assign phase_o  = phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_INIT;
        cnt_d   = '0;
      end
      PH_INIT: if (cnt_q == CNT_LAST) begin
        phase_d = PH_WRITE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      PH_WRITE: if (cnt_q == CNT_LAST) begin
        phase_d = PH_READ;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/lsq_cell.sv
module lsq_cell (
  input  logic clk,
  input  logic pulse_i,
  input  logic g_i,
  input  logic t1_i,
  input  logic t2_i,
  output logic bit_o
);
  // Nonvolatile storage: deliberately not cleared by reset
  logic bit_q, bit_d;

  always_comb begin
    bit_d = (bit_q & ~g_i) | (bit_q & g_i & t1_i) |
            (bit_q & g_i & ~t1_i & ~t2_i) | (~bit_q & g_i & t1_i & ~t2_i);
  end

  always_ff @(posedge clk) begin
    if (pulse_i) bit_q <= bit_d;
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/stateful_logic_seq.sv
module stateful_logic_seq
  import lsq_pkg::*;
#(
  parameter int PULSE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [3:0] func_i,
  input  logic       p_i,
  input  logic       q_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       result_o,
  output logic       pulse_o,
  output logic       drv_g_o,
  output logic       drv_t1_o,
  output logic       drv_t2_o
);
  phase_e     phase;
  logic       accept;
  logic [3:0] func_q;
  logic       p_q, q_q;
  logic       init_val;
  logic [2:0] write_drv;
  logic [2:0] drv;
  logic       cell_bit;
  logic       result_q;
  logic       done_q;

  lsq_phase_ctrl #(.PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .phase_o  (phase),
    .accept_o (accept)
  );

  // Operand capture, clock-enabled by acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      func_q <= func_i;
      p_q    <= p_i;
      q_q    <= q_i;
    end
  end

  lsq_recipe_decode u_dec (
    .func_i      (func_q),
    .p_i         (p_q),
    .q_i         (q_q),
    .init_val_o  (init_val),
    .write_drv_o (write_drv)
  );

  always_comb begin
    unique case (phase)
      PH_INIT:  drv = init_val ? 3'b110 : 3'b101;
      PH_WRITE: drv = write_drv;
      PH_READ:  drv = 3'b100;
      default:  drv = 3'b000;
    endcase
  end

  assign pulse_o = (phase == PH_INIT) || (phase == PH_WRITE);

  lsq_cell u_cell (
    .clk     (clk),
    .pulse_i (pulse_o),
    .g_i     (drv[2]),
    .t1_i    (drv[1]),
    .t2_i    (drv[0]),
    .bit_o   (cell_bit)
  );

  // Result register keeps its value through reset
  always_ff @(posedge clk) begin
    if (phase == PH_READ) result_q <= cell_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (phase == PH_READ);
  end

  assign ready_o  = (phase == PH_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign drv_g_o  = drv[2];
  assign drv_t1_o = drv[1];
  assign drv_t2_o = drv[0];

endmodule

// File: rtl/lsq_checker.sv
module lsq_checker (
  input logic clk,
  input logic rst_n,
  input logic pulse_i,
  input logic g_i,
  input logic t1_i,
  input logic t2_i,
  input logic cell_i,
  input logic ready_i,
  input logic done_i,
  input logic result_i
);
  logic armed_q;     // a pulse has defined the cell since reset
  logic have_res_q;  // a result has been produced since reset

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      have_res_q <= 1'b0;
    end else begin
      armed_q    <= armed_q | pulse_i;
      have_res_q <= have_res_q | done_i;
    end
  end

  assert_set_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && g_i && t1_i && !t2_i) |=> cell_i);

  assert_clear_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && g_i && !t1_i && t2_i) |=> !cell_i);

  assert_cell_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !pulse_i) |=> (cell_i == $past(cell_i)));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |-> !ready_i);

  assert_read_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_i && !ready_i) |-> (g_i && !t1_i && !t2_i));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (have_res_q && !done_i) |-> $stable(result_i));

endmodule

bind stateful_logic_seq lsq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pulse_i  (pulse_o),
  .g_i      (drv_g_o),
  .t1_i     (drv_t1_o),
  .t2_i     (drv_t2_o),
  .cell_i   (cell_bit),
  .ready_i  (ready_o),
  .done_i   (done_o),
  .result_i (result_o)
);

// File: tb/stateful_logic_seq_tb_top.sv
`timescale 1ns/1ps
module stateful_logic_seq_tb_top;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [3:0] func_i;
  logic       p_i, q_i;
  logic       ready_o, done_o, result_o, pulse_o;
  logic       drv_g_o, drv_t1_o, drv_t2_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic exp_q[$];
  int   cyc_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stateful_logic_seq #(.PULSE_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
    .p_i(p_i), .q_i(q_i), .ready_o(ready_o), .done_o(done_o),
    .result_o(result_o), .pulse_o(pulse_o), .drv_g_o(drv_g_o),
    .drv_t1_o(drv_t1_o), .drv_t2_o(drv_t2_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Monitor: scoreboard pop, latency, pulse width, single-cycle done, result hold
  int   pulse_cnt = 0;
  logic prev_done = 1'b0;
  logic have_res  = 1'b0;
  logic last_res  = 1'b0;
  always @(negedge clk) begin
    if (pulse_o) pulse_cnt++;
    if (done_o) begin
      check(!prev_done, "R8 done single cycle", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7/R9 unexpected done", 1, 0);
      end else begin
        logic e;
        int   c;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        check(result_o == e, "R1 R2 result", result_o, e);
        check(cyc - c == 2*P + 2, "R5 completion latency", cyc - c, 2*P + 2);
        check(pulse_cnt == 2*P, "R5 pulse width", pulse_cnt, 2*P);
      end
      pulse_cnt = 0;
      have_res  = 1'b1;
      last_res  = result_o;
    end else if (have_res) begin
      if (result_o != last_res) check(1'b0, "R8 result hold", result_o, last_res);
    end
    prev_done = done_o;
  end

  // Driver: one operation, optional busy start during the initialize pulse
  task automatic run_op(input logic [3:0] f, input logic p, input logic q, input bit busy_poke);
    logic [2:0] d;
    while (!ready_o) @(negedge clk);
    start_i = 1'b1; func_i = f; p_i = p; q_i = q;
    exp_q.push_back(f[{p, q}]);
    cyc_q.push_back(cyc);
    @(negedge clk);
    start_i = 1'b0;
    d = {drv_g_o, drv_t1_o, drv_t2_o};
    if (f == 4'h0 || f == 4'h8) check(d == 3'b101, "R3 init to 0", d, 3'b101);
    if (f == 4'hF || f == 4'h7) check(d == 3'b110, "R3 init to 1", d, 3'b110);
    if (f == 4'hC) check(d == (p ? 3'b110 : 3'b101), "R3 init to p", d, p ? 6 : 5);
    if (f == 4'hA) check(d == (q ? 3'b110 : 3'b101), "R3 init to q", d, q ? 6 : 5);
    if (busy_poke) begin
      start_i = 1'b1; func_i = ~f; p_i = ~p; q_i = ~q;
      @(negedge clk);
      start_i = 1'b0;
      check(ready_o == 1'b0, "R7 busy not ready", ready_o, 0);
      repeat (P - 1) @(negedge clk);
    end else begin
      repeat (P) @(negedge clk);
    end
    d = {drv_g_o, drv_t1_o, drv_t2_o};
    if (f == 4'h7) check(d == {p, 1'b0, q}, "R4 nand write drive", d, {p, 1'b0, q});
    repeat (P) @(negedge clk);
    d = {drv_g_o, drv_t1_o, drv_t2_o};
    check(!pulse_o && d == 3'b100, "R6 read step levels", {pulse_o, d}, 4);
    @(negedge clk);
    check(done_o == 1'b1, "R5 done timing", done_o, 1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; func_i = '0; p_i = 1'b0; q_i = 1'b0;
    repeat (3) @(negedge clk);
    check(ready_o == 1'b1 && done_o == 1'b0, "R9 reset state", {ready_o, done_o}, 2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: exhaustive function/operand sweep
    for (int f = 0; f < 16; f++)
      for (int pq = 0; pq < 4; pq++)
        run_op(4'(f), pq[1], pq[0], 1'b0);

    // R7: start while busy is ignored
    run_op(4'h7, 1'b1, 1'b1, 1'b1);
    run_op(4'h6, 1'b1, 1'b0, 1'b1);
    repeat (4) @(negedge clk);

    // R9: reset while idle keeps result
    begin
      logic keep;
      keep = result_o;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check(result_o == keep, "R9 result kept over reset", result_o, keep);
    end

    // R9: reset mid-operation, no done follows
    begin
      logic keep;
      keep = result_o;
      while (!ready_o) @(negedge clk);
      start_i = 1'b1; func_i = ~{3'b000, keep}; p_i = 1'b0; q_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(ready_o == 1'b1, "R9 idle after reset", ready_o, 1);
      rst_n = 1'b1;
      for (int k = 0; k < 3*P; k++) begin
        @(negedge clk);
        check(done_o == 1'b0, "R9 no done after abort", done_o, 0);
      end
      check(result_o == keep, "R9 result unchanged", result_o, keep);
      pulse_cnt = 0;
    end

    // operations still work after the abort
    run_op(4'h8, 1'b1, 1'b1, 1'b0);
    run_op(4'h1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule